// File: doc/BRIEF.md
# Pixel Time-over-Threshold and Arrival-Time Counter

This block is the digital half of one pixel in a hybrid detector matrix. It sees a qualified event: the discriminator output, optionally ORed with an injected test pulse, and blocked by a per-pixel mask. While the shutter is open it measures two things at once. The first is how many acquisition clocks the event stays high (time over threshold). The second is how many clocks pass between shutter opening and the first event (time of arrival). A sticky hit flag records that the pixel saw anything at all. Both counters are short maximal-length LFSRs rather than binary counters, which keeps the per-pixel logic to a shift and one XOR. Each counter stops at its last state instead of wrapping.

A calibration mode turns the time-over-threshold counter into a counter of event rising edges and freezes the arrival counter. In readout mode the hit flag and the two counters form one serial shift segment. Serial data comes in from the neighbouring pixel and the hit flag is the first bit out, so a column of pixels forms a single chain. Downstream logic can use that leading flag to skip pixels that were not hit.

Top module: `pxl_timecount`

## Requirements
- R1: After reset, both counters hold the seed code 4'b0001 (count 0), the hit flag is 0 and `ro_dout` is 0.
- R2: Counter codes follow the LFSR q_next = {q[2:0], q[3]^q[2]} from the seed 0001. Counts 0 to 14 map to 0001, 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111, 1110, 1100, 1000.
- R3: In normal mode, with the shutter open and not in its opening cycle, the ToT counter advances once for every clock on which the qualified event is high.
- R4: In normal mode, the ToA counter advances on each open-shutter clock while the hit flag is 0 and the event is low. From the first event onward it holds, so it reads the number of open clocks before the first event.
- R5: Each counter stops at code 1000 (count 14) and holds it instead of wrapping.
- R6: The first clock with the shutter high after it was low clears both counters to the seed and the hit flag to 0. An event in that same clock is not counted.
- R7: With the counting-mode bit set, the ToT counter advances once per rising edge of the qualified event, and the ToA counter holds.
- R8: The hit flag is set by any qualified event during an open shutter (after the opening clock). It stays set until the next clear.
- R9: With the mask bit set, the discriminator and test pulse have no effect: no hit, no ToT count. The ToA counter keeps counting.
- R10: The test-pulse input reaches the pixel only when the test-pulse enable bit is 1.
- R11: With the shutter low and readout off, the counters and the hit flag hold whatever the event inputs do.
- R12: When `ro_mode` is high, the segment {hit, ToT[3:0], ToA[3:0]} shifts one place toward the hit end on each clock. `ro_din` enters ToA bit 0 and `ro_dout` shows the hit flag. Readout takes precedence over acquisition and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition and readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter | input | 1 | Acquisition window, high while open |
| ro_mode | input | 1 | Serial readout mode select |
| ro_din | input | 1 | Serial data from the previous pixel |
| disc_in | input | 1 | Discriminator output |
| tp_in | input | 1 | Injected test pulse |
| tp_en | input | 1 | Lets the test pulse reach the pixel |
| mask_cfg | input | 1 | Blocks all event detection |
| cnt_mode | input | 1 | Calibration event-counting mode |
| tot_q | output | 4 | ToT counter code |
| toa_q | output | 4 | ToA counter code |
| hit_flag | output | 1 | Event seen since last clear |
| ro_dout | output | 1 | Serial data to the next pixel |

## Verification
Shutter opening and a live event can fall in the same clock, and so can readout and acquisition. The bench raises the discriminator in the very clock the shutter opens. It expects the clear to win: ToT at count 0, the hit flag low, and ToA counting only the clocks that follow. It also holds the discriminator high for the whole serial readout. It then judges the shifted bits and the final counter contents against the serial pattern alone.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_ACQ   = 2'd2,
    OP_SHIFT = 2'd3
  } pxl_op_e;
endpackage

// File: rtl/pxl_evt_qual.sv
module pxl_evt_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic disc_in,
  input  logic tp_in,
  input  logic tp_en,
  input  logic mask_cfg,
  output logic ev,
  output logic ev_rise
);
  logic ev_d;

  // event source: discriminator, plus the test pulse when enabled, both behind the mask
  assign ev      = (disc_in | (tp_en & tp_in)) & ~mask_cfg;
  assign ev_rise = ev & ~ev_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_d <= 1'b0;
    else        ev_d <= ev;
  end
endmodule

// File: rtl/pxl_lfsr_cnt.sv
module pxl_lfsr_cnt #(
  parameter int          W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pxl_pkg::pxl_op_e op,
  input  logic            adv,
  input  logic            sin,
  output logic [W-1:0]    q,
  output logic            sat,
  output logic            sout
);
  import pxl_pkg::*;

  function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] lfsr_last();
    logic [W-1:0] s;
    s = {{(W-1){1'b0}}, 1'b1};
    for (int i = 0; i < (1 << W) - 2; i++) s = lfsr_step(s);
    return s;
  endfunction

  localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LAST = lfsr_last();

  assign sat  = (q == LAST);
  assign sout = q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else begin
      case (op)
        OP_SHIFT: q <= {q[W-2:0], sin};
        OP_CLEAR: q <= SEED;
        OP_ACQ:   if (adv && !sat) q <= lfsr_step(q);
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pxl_timecount.sv
module pxl_timecount #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shutter,
  input  logic         ro_mode,
  input  logic         ro_din,
  input  logic         disc_in,
  input  logic         tp_in,
  input  logic         tp_en,
  input  logic         mask_cfg,
  input  logic         cnt_mode,
  output logic [W-1:0] tot_q,
  output logic [W-1:0] toa_q,
  output logic         hit_flag,
  output logic         ro_dout
);
  import pxl_pkg::*;

  logic     shutter_d, shutter_rise, acq_cyc;
  logic     ev, ev_rise, tot_adv, toa_adv;
  logic     tot_sat, toa_sat, toa_sout, tot_sout;
  pxl_op_e  op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shutter_d <= 1'b0;
    else        shutter_d <= shutter;
  end

  assign shutter_rise = shutter & ~shutter_d;

  always_comb begin
    if (ro_mode)           op = OP_SHIFT;
    else if (shutter_rise) op = OP_CLEAR;
    else if (shutter)      op = OP_ACQ;
    else                   op = OP_HOLD;
  end

  assign acq_cyc = (op == OP_ACQ);

  pxl_evt_qual u_evt (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .tp_in(tp_in),
    .tp_en(tp_en), .mask_cfg(mask_cfg), .ev(ev), .ev_rise(ev_rise)
  );

  assign tot_adv = cnt_mode ? ev_rise : ev;
  assign toa_adv = ~cnt_mode & ~hit_flag & ~ev;

  pxl_lfsr_cnt #(.W(W), .TAPS(TAPS)) u_toa (
    .clk(clk), .rst_n(rst_n), .op(op), .adv(toa_adv), .sin(ro_din),
    .q(toa_q), .sat(toa_sat), .sout(toa_sout)
  );

  pxl_lfsr_cnt #(.W(W), .TAPS(TAPS)) u_tot (
    .clk(clk), .rst_n(rst_n), .op(op), .adv(tot_adv), .sin(toa_sout),
    .q(tot_q), .sat(tot_sat), .sout(tot_sout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_flag <= 1'b0;
    else begin
      case (op)
        OP_SHIFT: hit_flag <= tot_sout;
        OP_CLEAR: hit_flag <= 1'b0;
        OP_ACQ:   hit_flag <= hit_flag | ev;
        default:  hit_flag <= hit_flag;
      endcase
    end
  end

  assign ro_dout = hit_flag;
endmodule

// File: rtl/pxl_timecount_chk.sv
module pxl_timecount_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ro_mode,
  input logic         mask_cfg,
  input logic         cnt_mode,
  input logic         shutter,
  input logic         shutter_rise,
  input logic         acq_cyc,
  input logic         tot_sat,
  input logic         toa_sat,
  input logic [W-1:0] tot_q,
  input logic [W-1:0] toa_q,
  input logic         hit_flag,
  input logic         ro_dout
);
  localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

  AST_TOT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cyc && tot_sat |=> $stable(tot_q)); // R5
  AST_TOA_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cyc && toa_sat |=> $stable(toa_q)); // R5
  AST_OPEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_rise && !ro_mode |=> (tot_q == SEED) && (toa_q == SEED) && !hit_flag); // R6
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag && !shutter_rise && !ro_mode |=> hit_flag); // R8
  AST_TOA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cyc && hit_flag |=> $stable(toa_q)); // R4
  AST_CALIB_TOA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cyc && cnt_mode |=> $stable(toa_q)); // R7
  AST_MASK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cyc && mask_cfg |=> hit_flag == $past(hit_flag)); // R9
  AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter && !ro_mode |=> $stable(tot_q) && $stable(toa_q) && $stable(hit_flag)); // R11
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ro_mode |=> ro_dout == $past(tot_q[W-1])); // R12
endmodule

bind pxl_timecount pxl_timecount_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ro_mode(ro_mode), .mask_cfg(mask_cfg),
  .cnt_mode(cnt_mode), .shutter(shutter), .shutter_rise(shutter_rise),
  .acq_cyc(acq_cyc), .tot_sat(tot_sat), .toa_sat(toa_sat),
  .tot_q(tot_q), .toa_q(toa_q), .hit_flag(hit_flag), .ro_dout(ro_dout)
);

// File: tb/sim_pxl_timecount.sv
`timescale 1ns/1ps
module sim_pxl_timecount;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutter = 0, ro_mode = 0, ro_din = 0, disc_in = 0, tp_in = 0;
  logic tp_en = 0, mask_cfg = 0, cnt_mode = 0;
  logic [3:0] tot_q, toa_q;
  logic hit_flag, ro_dout;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // code sequence from R2, written out independently of the design
  logic [3:0] code_tab [15] = '{4'b0001, 4'b0010, 4'b0100, 4'b1001, 4'b0011,
                                4'b0110, 4'b1101, 4'b1010, 4'b0101, 4'b1011,
                                4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000};

  always #4 clk = ~clk;

  pxl_timecount u0 (
    .clk(clk), .rst_n(rst_n), .shutter(shutter), .ro_mode(ro_mode),
    .ro_din(ro_din), .disc_in(disc_in), .tp_in(tp_in), .tp_en(tp_en),
    .mask_cfg(mask_cfg), .cnt_mode(cnt_mode), .tot_q(tot_q), .toa_q(toa_q),
    .hit_flag(hit_flag), .ro_dout(ro_dout)
  );

  function automatic int decode(input logic [3:0] c);
    for (int i = 0; i < 15; i++) if (code_tab[i] == c) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_counts(input string tag, input int e_tot, input int e_toa, input int e_hit);
    chk({tag, " tot"}, decode(tot_q), e_tot);
    chk({tag, " toa"}, decode(toa_q), e_toa);
    chk({tag, " hit"}, int'(hit_flag), e_hit);
  endtask

  // open shutter, k quiet clocks, m clocks of event, then close
  task automatic acq_run(input int k, input int m, input bit use_tp);
    @(negedge clk); shutter = 1; disc_in = 0; tp_in = 0;
    for (int i = 0; i < k; i++) begin @(negedge clk); disc_in = 0; tp_in = 0; end
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      if (use_tp) tp_in = 1; else disc_in = 1;
    end
    @(negedge clk); disc_in = 0; tp_in = 0; shutter = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_counts("R1 reset", 0, 0, 0);
    chk("R1 dout", int'(ro_dout), 0);
  endtask

  task automatic t_basic();
    acq_run(3, 5, 0);
    chk_counts("R3 R4 R8 basic", 5, 3, 1);
    chk("R2 tot code", int'(tot_q), int'(4'b0110));
    chk("R2 toa code", int'(toa_q), int'(4'b1001));
  endtask

  task automatic t_testpulse();
    tp_en = 1;
    acq_run(6, 2, 1);
    chk_counts("R10 tp enabled", 2, 6, 1);
    tp_en = 0;
    acq_run(2, 4, 1);
    chk_counts("R10 tp disabled", 0, 6, 0);
  endtask

  task automatic t_mask();
    mask_cfg = 1;
    acq_run(1, 3, 0);
    chk_counts("R9 masked", 0, 4, 0);
    mask_cfg = 0;
  endtask

  task automatic t_saturate();
    acq_run(0, 20, 0);
    chk_counts("R5 tot sat", 14, 0, 1);
    acq_run(20, 0, 0);
    chk_counts("R5 toa sat", 0, 14, 0);
  endtask

  task automatic t_open_clash();
    @(negedge clk); shutter = 1; disc_in = 1;
    @(negedge clk); disc_in = 0;
    @(negedge clk);
    @(negedge clk); shutter = 0;
    @(negedge clk);
    chk_counts("R6 clear beats event", 0, 2, 0);
  endtask

  task automatic t_calib();
    bit pat [8] = '{1, 1, 0, 1, 0, 1, 1, 0};
    cnt_mode = 1;
    @(negedge clk); shutter = 1; disc_in = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); disc_in = pat[i]; end
    @(negedge clk); disc_in = 0; shutter = 0;
    @(negedge clk);
    chk_counts("R7 calib edges", 3, 0, 1);
  endtask

  task automatic t_closed();
    @(negedge clk); disc_in = 1;
    repeat (3) @(negedge clk);
    disc_in = 0;
    @(negedge clk);
    chk_counts("R11 closed hold", 3, 0, 1);
    cnt_mode = 0;
  endtask

  task automatic t_readout();
    bit exp_bits [9];
    bit din [9] = '{0, 1, 1, 0, 1, 0, 0, 1, 1};
    acq_run(3, 5, 0);
    exp_bits[0] = hit_flag;
    for (int i = 0; i < 4; i++) exp_bits[1+i] = code_tab[5][3-i];
    for (int i = 0; i < 4; i++) exp_bits[5+i] = code_tab[3][3-i];
    disc_in = 1; ro_mode = 1;
    for (int i = 0; i < 9; i++) begin
      chk($sformatf("R12 serial bit %0d", i), int'(ro_dout), int'(exp_bits[i]));
      ro_din = din[i];
      @(negedge clk);
    end
    ro_mode = 0; disc_in = 0; ro_din = 0;
    chk("R12 hit after shift", int'(hit_flag), 0);
    chk("R12 tot after shift", int'(tot_q), int'(4'b1101));
    chk("R12 toa after shift", int'(toa_q), int'(4'b0011));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_testpulse();
    t_mask();
    t_saturate();
    t_open_clash();
    t_calib();
    t_closed();
    t_readout();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule